// File: doc/BRIEF.md
# Dual-Slope / Single-Slope PWM Timer

This block is an 8-bit timer with one compare channel that produces a pulse-width modulated waveform. A single counter serves two waveform shapes. In single-slope mode it counts upward and wraps. In dual-slope mode it climbs to the top value and then descends, which gives a waveform that is symmetric about the turning point. A clock-select field picks the rate at which the counter advances, from every system clock down to one step in 1024 clocks, or stops it.

The host loads a compare value with a one-cycle write strobe. The write lands in a holding register, and the comparator sees it only at a fixed point of the count cycle, so a duty change never produces a glitch in mid-period. A two-bit output-mode field sets how a compare match drives the waveform pin: toggle, clear, set, or disconnected. The meaning of these codes depends on the waveform mode. The block raises a one-clock compare-match pulse and a one-clock overflow pulse for the surrounding logic.

Top module: `pwm8_timer`

## Requirements
- R1: `clk_sel` codes 1 to 7 advance the counter once every 1, 8, 32, 64, 128, 256 and 1024 system clocks. Code 0 freezes the counter.
- R2: With `wave_mode`=0 (single-slope), the counter steps 0,1,...,255 and then returns to 0.
- R3: With `wave_mode`=1 (dual-slope), the counter steps up from 0 to 255 and then back down to 0. The values 255 and 0 each last exactly one counter step, so one full period is 510 steps.
- R4: In dual-slope mode, `out_mode`=2 drives the pin low on a match while counting up and high on a match while counting down. `out_mode`=3 does the opposite. `out_mode`=1 keeps the pin low.
- R5: In single-slope mode, `out_mode`=2 drives the pin high on the step that returns the counter to 0 and low on a match. `out_mode`=3 drives the opposite levels.
- R6: Extreme compare values. In single-slope `out_mode`=2, a compare value of 0 gives a high pulse lasting one counter step in every 256 steps, and a compare value of 255 holds the pin constantly high (constantly low with `out_mode`=3). In dual-slope `out_mode`=2, a compare value of 0 holds the pin low and 255 holds it high.
- R7: In single-slope mode, `out_mode`=1 inverts the pin on every match, giving a 50% duty square wave with a period of 512 counter steps.
- R8: A `cmp_wr` pulse stores `cmp_wdata` in a holding register. The compare logic uses the new value only after a transfer: in single-slope mode on the step from 255 to 0, in dual-slope mode on the step from 254 up to 255.
- R9: `ovf_flag` is high for exactly one clock, in the cycle where `count` first shows 0 after a wrap (single-slope) or after the descent (dual-slope).
- R10: `match_flag` is high for one clock, in the cycle after a counter step taken while `count` equalled the active compare value.
- R11: `out_mode`=0 holds `wave_out` low in both waveform modes.
- R12: While `rst` is high on a clock edge, the block sets `count`, `wave_out`, `match_flag`, `ovf_flag` and both compare registers to 0 from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wave_mode | input | 1 | 0 = single-slope, 1 = dual-slope |
| out_mode | input | 2 | Compare output action (0 off, 1 toggle, 2 clear-on-match, 3 set-on-match) |
| clk_sel | input | 3 | Counter step rate select, 0 = stopped |
| cmp_wr | input | 1 | Write strobe for the compare holding register |
| cmp_wdata | input | 8 | Compare value to write |
| wave_out | output | 1 | PWM waveform pin |
| count | output | 8 | Current counter value |
| match_flag | output | 1 | One-clock compare-match pulse |
| ovf_flag | output | 1 | One-clock pulse when the counter returns to 0 |

## Verification
The hardest behaviour to provoke is the holding-register transfer. A write has visible effect only if the counter crosses its transfer point while the compare value still differs, and the output is judged against the old value until then. The stimulus therefore writes new compare values at arbitrary points in a period. It then runs each setting for more than one full single-slope or dual-slope period, so that the first period after a write still shows the old duty and the following one shows the new duty. The extreme compare values 0 and 255 are reached the same way, by writing them and waiting past the transfer. Long runs at the 1/8 and 1/1024 rates, and a stretch with the counter stopped, cover the rate selection.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;

   typedef enum logic [1:0] {
      OM_OFF    = 2'd0,
      OM_TOGGLE = 2'd1,
      OM_CLEAR  = 2'd2,
      OM_SET    = 2'd3
   } out_mode_e;

   // number of low prescaler bits that must all be set for a step
   function automatic int sel_shift(input int sel);
      case (sel)
         2: return 3;
         3: return 5;
         4: return 6;
         5: return 7;
         6: return 8;
         7: return 10;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/pwm8_prescale.sv
module pwm8_prescale #(
   parameter int PRE_W = 10
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [2:0] sel,
   output logic       tick
);
   if (PRE_W < 10) begin : g_bad_pre
      $error("pwm8_prescale: PRE_W must cover the 1024 divider");
   end

   logic [PRE_W-1:0] pre_q;
   logic [7:0]       tap;

   always_ff @(posedge clk) begin
      if (rst) pre_q <= '0;
      else     pre_q <= pre_q + 1'b1;
   end

   assign tap[0] = 1'b0;
   assign tap[1] = 1'b1;

   for (genvar i = 2; i < 8; i++) begin : g_tap
      localparam int SH = pwm8_pkg::sel_shift(i);
      assign tap[i] = &pre_q[SH-1:0];
   end

   assign tick = tap[sel];
endmodule

// File: rtl/pwm8_counter.sv
module pwm8_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             dual,
   output logic [CNT_W-1:0] cnt,
   output logic             step_up
);
   localparam logic [CNT_W-1:0] TOP = '1;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic down_q;

   assign step_up = !dual || (cnt == '0) || ((cnt != TOP) && !down_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt    <= '0;
         down_q <= 1'b0;
      end else if (tick) begin
         cnt    <= step_up ? cnt + ONE : cnt - ONE;
         down_q <= dual && !step_up;
      end else if (!dual) begin
         down_q <= 1'b0;
      end
   end
endmodule

// File: rtl/pwm8_ocunit.sv
module pwm8_ocunit #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             dual,
   input  logic [1:0]       out_mode,
   input  logic [CNT_W-1:0] cnt,
   input  logic             step_up,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] ocr_q,
   output logic             oc_q,
   output logic             match_q,
   output logic             ovf_q
);
   import pwm8_pkg::*;

   localparam logic [CNT_W-1:0] TOP      = '1;
   localparam logic [CNT_W-1:0] NEAR_TOP = {{(CNT_W-1){1'b1}}, 1'b0};
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

   logic [CNT_W-1:0] buf_q;
   logic             hit, to_bottom, xfer;
   logic             oc_d;
   out_mode_e        om;

   assign om        = out_mode_e'(out_mode);
   assign hit       = tick && (cnt == ocr_q);
   assign to_bottom = tick && (dual ? (!step_up && cnt == ONE) : (cnt == TOP));
   assign xfer      = tick && (dual ? (step_up && cnt == NEAR_TOP) : (cnt == TOP));

   always_comb begin
      oc_d = oc_q;
      if (dual) begin
         unique case (om)
            OM_CLEAR: if (hit) oc_d = !step_up;
            OM_SET:   if (hit) oc_d = step_up;
            default:  oc_d = oc_q;
         endcase
      end else begin
         unique case (om)
            OM_TOGGLE: if (hit) oc_d = !oc_q;
            OM_CLEAR: begin
               if (to_bottom)  oc_d = 1'b1;
               else if (hit)   oc_d = 1'b0;
            end
            OM_SET: begin
               if (to_bottom)  oc_d = 1'b0;
               else if (hit)   oc_d = 1'b1;
            end
            default: oc_d = oc_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         buf_q   <= '0;
         ocr_q   <= '0;
         oc_q    <= 1'b0;
         match_q <= 1'b0;
         ovf_q   <= 1'b0;
      end else begin
         if (wr)   buf_q <= wdata;
         if (xfer) ocr_q <= buf_q;
         oc_q    <= oc_d;
         match_q <= hit;
         ovf_q   <= to_bottom;
      end
   end
endmodule

// File: rtl/pwm8_timer.sv
module pwm8_timer #(
   parameter int CNT_W = 8,
   parameter int PRE_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wave_mode,
   input  logic [1:0]       out_mode,
   input  logic [2:0]       clk_sel,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] cmp_wdata,
   output logic             wave_out,
   output logic [CNT_W-1:0] count,
   output logic             match_flag,
   output logic             ovf_flag
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("pwm8_timer: CNT_W must be at least 2");
   end

   logic             tick, step_up, oc_q, pin_en;
   logic [CNT_W-1:0] ocr_q;

   pwm8_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk  (clk),
      .rst  (rst),
      .sel  (clk_sel),
      .tick (tick)
   );

   pwm8_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .dual    (wave_mode),
      .cnt     (count),
      .step_up (step_up)
   );

   pwm8_ocunit #(.CNT_W(CNT_W)) u_oc (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .dual     (wave_mode),
      .out_mode (out_mode),
      .cnt      (count),
      .step_up  (step_up),
      .wr       (cmp_wr),
      .wdata    (cmp_wdata),
      .ocr_q    (ocr_q),
      .oc_q     (oc_q),
      .match_q  (match_flag),
      .ovf_q    (ovf_flag)
   );

   assign pin_en   = out_mode[1] || (out_mode == 2'd1 && !wave_mode);
   assign wave_out = pin_en && oc_q;
endmodule

// File: rtl/pwm8_timer_chk.sv
module pwm8_timer_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             wave_mode,
   input logic [1:0]       out_mode,
   input logic [2:0]       clk_sel,
   input logic [CNT_W-1:0] count,
   input logic             wave_out,
   input logic             match_flag,
   input logic             ovf_flag,
   input logic [CNT_W-1:0] ocr_act
);
   localparam logic [CNT_W-1:0] TOP      = '1;
   localparam logic [CNT_W-1:0] NEAR_TOP = {{(CNT_W-1){1'b1}}, 1'b0};

   a_r1_stopped_holds: assert property (@(posedge clk) disable iff (rst)
      clk_sel == 3'd0 |=> $stable(count));

   a_r2_fast_increments: assert property (@(posedge clk) disable iff (rst)
      (!wave_mode && clk_sel == 3'd1) |=> count == $past(count) + CNT_W'(1));

   a_r3_top_turns_down: assert property (@(posedge clk) disable iff (rst)
      (wave_mode && clk_sel == 3'd1 && count == TOP && $past(count) == NEAR_TOP)
      |=> count == NEAR_TOP);

   a_r4_dual_up_match_clears: assert property (@(posedge clk) disable iff (rst)
      (wave_mode && $past(wave_mode) && out_mode == 2'd2 && $past(out_mode) == 2'd2
       && match_flag && count > $past(count)) |-> !wave_out);

   a_r5_fast_bottom_sets: assert property (@(posedge clk) disable iff (rst)
      (!wave_mode && !$past(wave_mode) && out_mode == 2'd2 && $past(out_mode) == 2'd2
       && ovf_flag) |-> wave_out);

   a_r9_ovf_at_bottom: assert property (@(posedge clk) disable iff (rst)
      ovf_flag |-> count == '0);

   a_r10_match_on_compare: assert property (@(posedge clk) disable iff (rst)
      match_flag |-> $past(count) == $past(ocr_act));

   a_r11_off_is_low: assert property (@(posedge clk) disable iff (rst)
      out_mode == 2'd0 |-> !wave_out);
endmodule

bind pwm8_timer pwm8_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .wave_mode  (wave_mode),
   .out_mode   (out_mode),
   .clk_sel    (clk_sel),
   .count      (count),
   .wave_out   (wave_out),
   .match_flag (match_flag),
   .ovf_flag   (ovf_flag),
   .ocr_act    (ocr_q)
);

// File: tb/pwm8_timer_test.sv
`timescale 1ns/1ps
module pwm8_timer_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wave_mode = 1'b0;
   logic [1:0] out_mode = 2'd0;
   logic [2:0] clk_sel = 3'd1;
   logic       cmp_wr = 1'b0;
   logic [7:0] cmp_wdata = 8'd0;
   logic       wave_out, match_flag, ovf_flag;
   logic [7:0] count;

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 1'b0;
   string cur_tag  = "R12";

   typedef struct {
      logic [7:0] c;
      logic       w;
      logic       m;
      logic       o;
      string      tag;
   } exp_t;
   exp_t sb[$];

   always #10 clk = ~clk;   // 50 MHz

   pwm8_timer uut (
      .clk(clk), .rst(rst), .wave_mode(wave_mode), .out_mode(out_mode),
      .clk_sel(clk_sel), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
      .wave_out(wave_out), .count(count), .match_flag(match_flag), .ovf_flag(ovf_flag)
   );

   // ---------------- reference model built from the requirements ----------------
   int         m_pre;
   logic [7:0] m_cnt, m_ocr, m_buf;
   bit         m_down, m_pin, m_match, m_ovf;

   function automatic int step_div(input logic [2:0] s);   // R1
      case (s)
         3'd1: return 1;    3'd2: return 8;   3'd3: return 32;  3'd4: return 64;
         3'd5: return 128;  3'd6: return 256; default: return 1024;
      endcase
   endfunction

   always @(posedge clk) begin
      exp_t e;
      if (rst) begin                                  // R12
         m_pre = 0; m_cnt = 0; m_ocr = 0; m_buf = 0;
         m_down = 0; m_pin = 0; m_match = 0; m_ovf = 0;
      end else begin
         bit adv, rising, hit, bottom, xfer;
         adv   = (clk_sel != 0) && ((m_pre % step_div(clk_sel)) == step_div(clk_sel) - 1);
         m_pre = (m_pre + 1) % 1024;
         m_match = 0; m_ovf = 0;
         if (adv) begin
            if (!wave_mode)            m_down = 0;
            else if (m_cnt == 8'hFF)   m_down = 1;          // R3 turn at top
            else if (m_cnt == 8'h00)   m_down = 0;
            rising = !m_down;
            hit    = (m_cnt == m_ocr);
            bottom = wave_mode ? (!rising && m_cnt == 8'd1) : (m_cnt == 8'hFF);
            xfer   = wave_mode ? (rising && m_cnt == 8'hFE) : (m_cnt == 8'hFF);
            if (wave_mode) begin                           // R4
               if (out_mode == 2'd2 && hit) m_pin = !rising;
               if (out_mode == 2'd3 && hit) m_pin = rising;
            end else begin                                 // R5, R7
               if (out_mode == 2'd1 && hit) m_pin = !m_pin;
               if (out_mode == 2'd2) begin
                  if (bottom) m_pin = 1; else if (hit) m_pin = 0;
               end
               if (out_mode == 2'd3) begin
                  if (bottom) m_pin = 0; else if (hit) m_pin = 1;
               end
            end
            m_match = hit;                                 // R10
            m_ovf   = bottom;                              // R9
            if (xfer) m_ocr = m_buf;                       // R8
            m_cnt = rising ? m_cnt + 8'd1 : m_cnt - 8'd1;  // R2, R3
         end
         if (cmp_wr) m_buf = cmp_wdata;
      end
      e.c = m_cnt; e.w = m_pin; e.m = m_match; e.o = m_ovf; e.tag = cur_tag;
      sb.push_back(e);
   end

   // ---------------- monitor ----------------
   always @(negedge clk) begin
      if (sb.size() > 0 && !done) begin
         exp_t e;
         logic ew;
         e  = sb.pop_front();
         ew = (out_mode[1] || (out_mode == 2'd1 && !wave_mode)) ? e.w : 1'b0;  // R11
         n_checks++;
         if (count !== e.c || wave_out !== ew || match_flag !== e.m || ovf_flag !== e.o) begin
            n_fail++;
            $display("FAIL %s t=%0t: cnt/wave/match/ovf actual %h/%b/%b/%b expected %h/%b/%b/%b",
                     e.tag, $time, count, wave_out, match_flag, ovf_flag, e.c, ew, e.m, e.o);
         end
      end
   end

   // ---------------- driver ----------------
   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #2;
   endtask

   task automatic write_cmp(input logic [7:0] v);
      cmp_wr = 1'b1; cmp_wdata = v;
      cycles(1);
      cmp_wr = 1'b0;
   endtask

   task automatic setup(input string tag, input logic wm, input logic [1:0] om,
                        input logic [2:0] sel);
      cur_tag = tag; wave_mode = wm; out_mode = om; clk_sel = sel;
   endtask

   initial begin
      cur_tag = "R12";
      cycles(4);
      rst = 1'b0;
      cycles(3);

      setup("R2", 1'b0, 2'd2, 3'd1);  cycles(300);
      setup("R5", 1'b0, 2'd2, 3'd1);  write_cmp(8'h40); cycles(600);
      setup("R5", 1'b0, 2'd3, 3'd1);  cycles(300);
      setup("R6", 1'b0, 2'd2, 3'd1);  write_cmp(8'h00); cycles(600);
      setup("R6", 1'b0, 2'd2, 3'd1);  write_cmp(8'hFF); cycles(600);
      setup("R6", 1'b0, 2'd3, 3'd1);  cycles(300);
      setup("R7", 1'b0, 2'd1, 3'd1);  write_cmp(8'h80); cycles(1100);
      setup("R11", 1'b0, 2'd0, 3'd1); cycles(300);
      setup("R3", 1'b1, 2'd2, 3'd1);  write_cmp(8'h40); cycles(1100);
      setup("R4", 1'b1, 2'd3, 3'd1);  cycles(600);
      setup("R4", 1'b1, 2'd1, 3'd1);  cycles(300);
      setup("R11", 1'b1, 2'd0, 3'd1); cycles(300);
      setup("R6", 1'b1, 2'd2, 3'd1);  write_cmp(8'h00); cycles(1100);
      setup("R6", 1'b1, 2'd2, 3'd1);  write_cmp(8'hFF); cycles(1100);
      setup("R8", 1'b1, 2'd2, 3'd1);  cycles(137); write_cmp(8'h20); cycles(90);
      write_cmp(8'hC0); cycles(1100);
      setup("R8", 1'b0, 2'd2, 3'd1);  cycles(61); write_cmp(8'h10); cycles(700);
      setup("R9", 1'b1, 2'd3, 3'd1);  cycles(1100);
      setup("R10", 1'b0, 2'd1, 3'd1); write_cmp(8'h7F); cycles(600);
      setup("R1", 1'b0, 2'd2, 3'd2);  write_cmp(8'h10); cycles(4200);
      setup("R1", 1'b0, 2'd2, 3'd0);  cycles(300);
      setup("R1", 1'b1, 2'd2, 3'd3);  cycles(3000);
      setup("R1", 1'b0, 2'd2, 3'd7);  cycles(5000);
      setup("R12", 1'b0, 2'd2, 3'd1); rst = 1'b1; cycles(3); rst = 1'b0; cycles(50);

      @(negedge clk); @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual timeout expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule